// File: doc/BRIEF.md
# Power-Fail Chip-Enable Write Guard

This block sits between a memory controller and an SRAM and gates the active-low chip-enable strobe. While the supply is healthy the strobe passes through unchanged. When an external comparator reports that the supply has left its tolerance band, the block stops new accesses from reaching the SRAM, so the memory contents stay intact while the supply falls.

An access that is already under way when the failure is seen may finish. The block waits for it to end, or for a bounded grace window counted in millisecond ticks, and then latches the output inactive. It releases the output only after the power-fail flag clears.

Two comparator flags come in, one for each supply threshold, and a tolerance-select pin picks the one that counts. The strobe input and both flags are resynchronised before use. The analog comparators, the battery switch and the references stay outside the block and appear only as digital inputs.

Top module: `pf_ce_guard`

## Requirements
- R1: While the selected power-fail flag is clear and the guard is in its normal state, `ce_out_n` equals `ce_in_n`, delayed by the two synchroniser stages.
- R2: If `ce_in_n` is low when the selected flag is seen asserted, `ce_out_n` stays low for as long as `ce_in_n` stays low and the grace window has not run out.
- R3: Once `ce_in_n` goes high after a failure, `ce_out_n` goes high and stays high for as long as the selected flag stays asserted, whatever `ce_in_n` does.
- R4: When the selected flag clears during protection, the guard returns to its normal state and `ce_out_n` follows `ce_in_n` again.
- R5: With `tol_sel` = 0 the flag `pfail_3v0` (3.3 V supply, 3.0 V trip) is used. With `tol_sel` = 1 the flag `pfail_2v7` (3.0 V supply, 2.7 V trip) is used. The flag that is not selected has no effect.
- R6: If `ce_in_n` is still low when the grace window holds `TIMEOUT_TICKS` ticks of `tick_ms`, `ce_out_n` goes high in the cycle right after the clock edge that samples the last of those ticks (default 1500 ticks of 1 ms).
- R7: The grace tick count restarts from zero each time the grace state is entered.
- R8: If `ce_in_n` is high when the failure is seen, the guard goes straight to protection without a grace window. A later low on `ce_in_n` is then blocked.
- R9: While `rst_n` is low, `ce_out_n` is high and the guard is in protection. After reset it leaves protection only once the synchronised selected flag reads clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_ms | input | 1 | One-cycle tick enable for the grace window, synchronous to clk |
| ce_in_n | input | 1 | Active-low chip-enable from the memory controller |
| pfail_3v0 | input | 1 | Power-fail flag, 3.0 V threshold (high = failed) |
| pfail_2v7 | input | 1 | Power-fail flag, 2.7 V threshold (high = failed) |
| tol_sel | input | 1 | Threshold select: 0 uses pfail_3v0, 1 uses pfail_2v7 |
| ce_out_n | output | 1 | Gated active-low chip-enable to the SRAM |

## Verification
A table of steady-state settings is applied under both tolerance selections. The patterns are a strobe that toggles with power good, a strobe held low or high as the selected flag rises, and the unselected flag raised alone. Together they separate plain pass-through, the grace hold, latched protection and flag selection. Directed sequences then feed single ticks one at a time up to one short of the window and then one more, and they reuse the window after a short earlier visit. This shows whether the expiry lands on the exact tick and whether the count restarts on each entry. Further directed cases cover reset, the release from reset, and a failure that arrives while the strobe is idle.

// File: rtl/pfg_pkg.sv
// Package: shared state type for the power-fail chip-enable guard.
// Assumes: nothing beyond IEEE 1800-2017.
package pfg_pkg;

    typedef enum logic [1:0] {
        ST_NORMAL  = 2'd0,
        ST_GRACE   = 2'd1,
        ST_PROTECT = 2'd2
    } guard_state_t;

endpackage

// File: rtl/pfg_sync.sv
// Module: pfg_sync
// Two-stage (or deeper) resynchroniser for a vector of asynchronous levels.
// Assumes: each bit is an independent level; reset loads RST_VAL.
module pfg_sync #(
    parameter int          WIDTH   = 1,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    logic [WIDTH-1:0] chain [STAGES];

    // Shift the input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
        end else begin
            chain[0] <= d_async;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/pfg_timer.sv
// Module: pfg_timer
// Counts tick enables while run is high and flags the tick that completes
// the window. Count is held at zero whenever run is low.
// Assumes: tick is synchronous to clk; LIMIT >= 1.
module pfg_timer #(
    parameter int LIMIT = 1500,
    localparam int CW   = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          tick,
    output logic [CW-1:0] count,
    output logic          expire
);

    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    // Count ticks inside the window; clear outside it.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            count <= '0;
        end else if (tick && count != LAST) begin
            count <= count + 1'b1;
        end
    end

    // Flag the tick that completes the window.
    always_comb expire = run && tick && (count == LAST);

endmodule

// File: rtl/pfg_fsm.sv
// Module: pfg_fsm
// Three-state guard controller: normal pass-through, grace for an
// access in flight, and latched protection.
// Assumes: ce_s and pf_s are already synchronised.
module pfg_fsm
    import pfg_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ce_s,
    input  logic         pf_s,
    input  logic         expire,
    output guard_state_t state,
    output logic         in_grace,
    output logic         protect
);

    guard_state_t nxt;

    // Next-state selection.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_NORMAL:  if (pf_s) nxt = ce_s ? ST_PROTECT : ST_GRACE;
            ST_GRACE:   if (ce_s || expire) nxt = ST_PROTECT;
            ST_PROTECT: if (!pf_s) nxt = ST_NORMAL;
            default:    nxt = ST_PROTECT;
        endcase
    end

    // State register; reset parks the guard in protection.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_PROTECT;
        else        state <= nxt;
    end

    assign in_grace = (state == ST_GRACE);
    assign protect  = (state == ST_PROTECT);

endmodule

// File: rtl/pf_ce_guard.sv
// Module: pf_ce_guard (top)
// Gates an active-low SRAM chip-enable on a power-fail flag, letting an
// access in flight complete for up to TIMEOUT_TICKS ticks.
// Assumes: tick_ms is synchronous to clk; other inputs may be asynchronous.
module pf_ce_guard #(
    parameter int TIMEOUT_TICKS = 1500,
    parameter int SYNC_STAGES   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_ms,
    input  logic ce_in_n,
    input  logic pfail_3v0,
    input  logic pfail_2v7,
    input  logic tol_sel,
    output logic ce_out_n
);
    import pfg_pkg::*;

    localparam int CW = $clog2(TIMEOUT_TICKS + 1);

    logic [2:0]    raw_in;
    logic [2:0]    syn_in;
    logic          ce_s;
    logic          pf_s;
    logic          in_grace;
    logic          protect;
    logic          expire;
    logic [CW-1:0] tcount;
    guard_state_t  state;

    assign raw_in = {ce_in_n, pfail_3v0, pfail_2v7};

    // Strobe resets idle (high), flags reset as failed.
    pfg_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (raw_in),
        .q_sync  (syn_in)
    );

    assign ce_s = syn_in[2];

    // Pick the flag for the configured supply tolerance.
    always_comb pf_s = tol_sel ? syn_in[0] : syn_in[1];

    pfg_timer #(.LIMIT(TIMEOUT_TICKS)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (in_grace),
        .tick   (tick_ms),
        .count  (tcount),
        .expire (expire)
    );

    pfg_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_s     (ce_s),
        .pf_s     (pf_s),
        .expire   (expire),
        .state    (state),
        .in_grace (in_grace),
        .protect  (protect)
    );

    // Block the strobe while protecting; otherwise pass it through.
    always_comb ce_out_n = protect | ce_s;

endmodule

// File: rtl/pfg_chk.sv
// Module: pfg_chk
// Property checker for pf_ce_guard, attached by bind below.
// Assumes: connected to the guard's internal synchronised signals.
module pfg_chk
    import pfg_pkg::*;
#(
    parameter int CW = 11
) (
    input logic         clk,
    input logic         rst_n,
    input logic         ce_s,
    input logic         pf_s,
    input logic         expire,
    input logic [CW-1:0] tcount,
    input guard_state_t state,
    input logic         ce_out_n
);

    // R2
    grace_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_NORMAL && pf_s && !ce_s) |=> (state == ST_GRACE && !ce_out_n));

    // R1
    low_only_unprotected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ce_out_n) |-> (state != ST_PROTECT));

    // R3
    protect_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PROTECT && pf_s) |=> (state == ST_PROTECT && ce_out_n));

    // R4
    recover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PROTECT && !pf_s) |=> (state == ST_NORMAL));

    // R6
    timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GRACE && expire) |=> (state == ST_PROTECT && ce_out_n));

    // R7
    grace_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_NORMAL && pf_s && !ce_s) |=> (tcount == '0));

    // R8
    idle_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_NORMAL && pf_s && ce_s) |=> (state == ST_PROTECT));

    // R9
    reset_park_chk: assert property (@(posedge clk)
        !rst_n |=> (state == ST_PROTECT && ce_out_n));

endmodule

bind pf_ce_guard pfg_chk #(.CW(CW)) u_pfg_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_s     (ce_s),
    .pf_s     (pf_s),
    .expire   (expire),
    .tcount   (tcount),
    .state    (state),
    .ce_out_n (ce_out_n)
);

// File: tb/tb_pf_ce_guard.sv
module tb_pf_ce_guard;

    localparam int TO = 12;

    logic clk = 1'b0;
    logic rst_n, tick_ms, ce_in_n, pfail_3v0, pfail_2v7, tol_sel;
    logic ce_out_n;

    int errors = 0;
    int checks = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    pf_ce_guard #(.TIMEOUT_TICKS(TO)) dut (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .ce_in_n(ce_in_n),
        .pfail_3v0(pfail_3v0), .pfail_2v7(pfail_2v7), .tol_sel(tol_sel),
        .ce_out_n(ce_out_n)
    );

    always #10 clk = ~clk;

    // Vector fields: {ce_in_n, pfail_3v0, pfail_2v7, tol_sel, expected ce_out_n}
    localparam int NV = 14;
    localparam logic [4:0] VEC [NV] = '{
        5'b0_00_0_0,  // R1 follow low
        5'b1_00_0_1,  // R1 follow high
        5'b0_01_0_0,  // R5 unselected 2v7 flag ignored
        5'b1_01_0_1,  // R5
        5'b0_01_0_0,  // R5 still normal
        5'b0_10_0_0,  // R2 fail with strobe low: grace
        5'b1_10_0_1,  // R3 release -> protect
        5'b0_10_0_1,  // R3 held while flag set
        5'b0_00_0_0,  // R4 flag clear -> follow
        5'b0_10_1_0,  // R5 unselected 3v0 flag ignored
        5'b0_01_1_0,  // R2 selected 2v7 -> grace
        5'b1_01_1_1,  // R3
        5'b0_01_1_1,  // R3
        5'b0_10_1_0   // R4 / R5
    };
    localparam int VREQ [NV] = '{1,1,5,5,5,2,3,3,4,5,2,3,3,4};

    task automatic check(input logic exp, input string req);
        checks++;
        if (ce_out_n !== exp) begin
            errors++;
            $display("FAIL %s: ce_out_n=%b expected=%b at cycle %0d", req, ce_out_n, exp, cyc);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_ms = 1'b1;
            @(negedge clk);
            tick_ms = 1'b0;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 200000 && !done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; tick_ms = 1'b0; ce_in_n = 1'b0;
        pfail_3v0 = 1'b0; pfail_2v7 = 1'b0; tol_sel = 1'b0;
        wait_n(3);
        check(1'b1, "R9 output high in reset");
        rst_n = 1'b1;
        wait_n(1);
        check(1'b1, "R9 protect until synced flag clear");
        wait_n(4);
        check(1'b0, "R9 released after flag clear");

        for (int v = 0; v < NV; v++) begin
            {ce_in_n, pfail_3v0, pfail_2v7, tol_sel} = VEC[v][4:1];
            wait_n(4);
            check(VEC[v][0], $sformatf("R%0d table vector %0d", VREQ[v], v));
        end

        // R6: window expiry on the exact tick
        tol_sel = 1'b0; pfail_3v0 = 1'b1; ce_in_n = 1'b0;
        wait_n(4);
        ticks(TO - 1);
        check(1'b0, "R6 one tick short of window");
        ticks(1);
        check(1'b1, "R6 forced high at window end");
        ce_in_n = 1'b0;
        wait_n(2);
        check(1'b1, "R6 stays protected");
        pfail_3v0 = 1'b0;
        wait_n(4);
        check(1'b0, "R4 recovery after timeout");

        // R7: count restarts on each grace entry
        pfail_3v0 = 1'b1;
        wait_n(4);
        ticks(5);
        ce_in_n = 1'b1;
        wait_n(4);
        check(1'b1, "R3 release during partial window");
        ce_in_n = 1'b0; pfail_3v0 = 1'b0;
        wait_n(4);
        check(1'b0, "R4 follow again");
        pfail_3v0 = 1'b1;
        wait_n(4);
        ticks(TO - 1);
        check(1'b0, "R7 fresh window not cut short");
        ticks(1);
        check(1'b1, "R7 fresh window expires on full count");
        pfail_3v0 = 1'b0;
        wait_n(4);

        // R8: failure while strobe idle
        ce_in_n = 1'b1;
        wait_n(4);
        pfail_3v0 = 1'b1;
        wait_n(4);
        ce_in_n = 1'b0;
        wait_n(4);
        check(1'b1, "R8 new access blocked after idle failure");
        pfail_3v0 = 1'b0;
        wait_n(4);
        check(1'b0, "R4 follow after idle failure clears");

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule